// File: doc/BRIEF.md
# Boot-Window Segmented Address Former

This block turns a 16-bit segment and a 16-bit offset into a 32-bit physical bus address for a processor front end that comes out of reset in its 16-bit segmented mode. The segment is shifted left by four bits and added to the offset, so a carry out of the low 20 bits is real and reaches bit 20. An enable for address line 20 chooses whether that carry survives or is cleared, which gives the wrap-around at the 1 MB boundary that older software expects.

After reset the block drives the twelve upper address lines high. The first fetches therefore land in the boot ROM at the top of the 32-bit space, even though the segmented arithmetic only produces 20 bits. This boot window stays open until the front end commits its first far (inter-segment) jump. From then on the block produces plain zero-extended addresses until the next reset. While the window is open, an access whose sum carries past bit 19 is refused. Such an access would wrap below 0xFFF00000. The refusal is flagged, and no valid strobe is issued for it.

Each request is registered, and the result appears one cycle after the request is sampled.

Top module: `seg_addr_gen`

## Requirements
- R1: When the boot window is closed, a request with segment S and offset O and line 20 enabled yields addr_o = S*16 + O, zero-extended to 32 bits. This covers carries out of the low 20 bits.
- R2: With line 20 disabled, bit 20 of the sum is cleared before any further processing. In flat mode FFFF:FFF0 gives 0x0000FFE0 with line 20 disabled and 0x0010FFE0 with it enabled.
- R3: While the boot window is open, every non-faulting request yields addr_o[31:20] = 0xFFF and addr_o[19:0] = the low 20 bits of the sum.
- R4: The boot entry point is segment 0xF000 with offset 0xFFF0, which is linear 0xFFFF0. The first request with these values after reset yields addr_o = 0xFFFFFFF0.
- R5: While the window is open, a request whose sum (after line-20 gating) has bit 20 set gives fault_o = 1 and valid_o = 0 in the next cycle, and addr_o keeps its previous value.
- R6: A far-jump pulse sampled at an edge closes the window. A request sampled at the same edge still uses the forced address. Requests from the next edge on use flat addresses, with bits 31..21 zero.
- R7: Once closed, the window stays closed and further far jumps change nothing. Only reset reopens it.
- R8: valid_o and fault_o are one-cycle results of a request sampled at the previous edge. Without a request both are 0 and addr_o holds its value.
- R9: During and right after reset, addr_o = 0, valid_o = 0 and fault_o = 0, and the window is open.
- R10: valid_o and fault_o are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_i | input | 16 | Segment value |
| off_i | input | 16 | Offset value |
| req_i | input | 1 | Access request strobe |
| far_jump_i | input | 1 | Far-jump commit pulse |
| a20_en_i | input | 1 | 1 keeps the carry into address bit 20, 0 clears it |
| addr_o | output | 32 | Registered physical address |
| valid_o | output | 1 | Address accepted this cycle |
| fault_o | output | 1 | Access refused this cycle |

## Verification
The bench builds the block with its default parameters: 16-bit segment and offset, a shift of four, 32 physical bits and twelve forced lines. These are the only values at which the boot entry point and the 1 MB carry cases have their defined meaning. It sweeps 256 segment/offset pairs, spread over the whole segment range, with line 20 both disabled and enabled, once with the window open and once with it closed. This reaches carries into bit 20 in both modes. Directed steps cover the entry point, the same-edge far jump, repeated jumps, idle cycles and reopening by reset.

// File: rtl/sag_pkg.sv
package sag_pkg;

   typedef enum logic {
      WIN_FLAT = 1'b0,
      WIN_BOOT = 1'b1
   } win_mode_e;

   localparam logic [15:0] BOOT_SEG = 16'hF000;
   localparam logic [15:0] BOOT_OFF = 16'hFFF0;
   localparam int unsigned BOOT_LINEAR = 32'h000F_FFF0;

endpackage

// File: rtl/sag_sum.sv
module sag_sum #(
   parameter int unsigned SEG_W    = 16,
   parameter int unsigned OFF_W    = 16,
   parameter int unsigned SHIFT    = 4,
   parameter int unsigned SUM_W    = 21,
   parameter int unsigned GATE_BIT = 20,
   parameter bit          GATE_EN  = 1'b1
) (
   input  logic [SEG_W-1:0] seg_i,
   input  logic [OFF_W-1:0] off_i,
   input  logic             gate_open_i,
   output logic [SUM_W-1:0] sum_o
);

   localparam int unsigned SHL_W = SEG_W + SHIFT;

   logic [SHL_W-1:0] seg_shl;
   logic [SUM_W-1:0] raw_sum;

   initial begin
      assert (SUM_W > SHL_W && SUM_W > OFF_W)
         else $fatal(1, "sag_sum: SUM_W too narrow for the carry");
   end

   assign seg_shl = {seg_i, {SHIFT{1'b0}}};
   assign raw_sum = SUM_W'(seg_shl) + SUM_W'(off_i);

   generate
      if (GATE_EN && (GATE_BIT < SUM_W)) begin : g_gate
         always_comb begin
            sum_o           = raw_sum;
            sum_o[GATE_BIT] = raw_sum[GATE_BIT] & gate_open_i;
         end
      end else begin : g_nogate
         logic unused_gate;
         assign unused_gate = gate_open_i;
         assign sum_o       = raw_sum;
      end
   endgenerate

endmodule

// File: rtl/sag_window.sv
module sag_window
   import sag_pkg::*;
#(
   parameter int unsigned PHYS_W  = 32,
   parameter int unsigned FORCE_W = 12,
   parameter int unsigned SUM_W   = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              jump_i,
   input  logic [SUM_W-1:0]  sum_i,
   output win_mode_e         mode_o,
   output logic [PHYS_W-1:0] phys_o,
   output logic              over_o
);

   localparam int unsigned LOW_W = PHYS_W - FORCE_W;

   win_mode_e         mode_q;
   logic [PHYS_W-1:0] phys_boot;
   logic [PHYS_W-1:0] phys_flat;
   logic              carry_out;

   initial begin
      assert (FORCE_W > 0 && FORCE_W < PHYS_W)
         else $fatal(1, "sag_window: FORCE_W out of range");
      assert (SUM_W <= PHYS_W)
         else $fatal(1, "sag_window: sum wider than bus");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mode_q <= WIN_BOOT;
      else if (jump_i) mode_q <= WIN_FLAT;
   end

   assign mode_o    = mode_q;
   assign phys_flat = PHYS_W'(sum_i);

   generate
      if (SUM_W > LOW_W) begin : g_wide
         assign phys_boot = {{FORCE_W{1'b1}}, sum_i[LOW_W-1:0]};
         assign carry_out = |sum_i[SUM_W-1:LOW_W];
      end else begin : g_narrow
         assign phys_boot = {{FORCE_W{1'b1}}, LOW_W'(sum_i)};
         assign carry_out = 1'b0;
      end
   endgenerate

   always_comb begin
      if (mode_q == WIN_BOOT) begin
         phys_o = phys_boot;
         over_o = carry_out;
      end else begin
         phys_o = phys_flat;
         over_o = 1'b0;
      end
   end

   p_stays_flat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == WIN_FLAT) |=> (mode_q == WIN_FLAT));

   p_jump_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
      jump_i |=> (mode_q == WIN_FLAT));

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
   import sag_pkg::*;
#(
   parameter int unsigned SEG_W    = 16,
   parameter int unsigned OFF_W    = 16,
   parameter int unsigned SHIFT    = 4,
   parameter int unsigned PHYS_W   = 32,
   parameter int unsigned FORCE_W  = 12,
   parameter int unsigned GATE_BIT = 20,
   parameter bit          GATE_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEG_W-1:0]  seg_i,
   input  logic [OFF_W-1:0]  off_i,
   input  logic              req_i,
   input  logic              far_jump_i,
   input  logic              a20_en_i,
   output logic [PHYS_W-1:0] addr_o,
   output logic              valid_o,
   output logic              fault_o
);

   localparam int unsigned SHL_W = SEG_W + SHIFT;
   localparam int unsigned SUM_W = ((SHL_W > OFF_W) ? SHL_W : OFF_W) + 1;
   localparam int unsigned LOW_W = PHYS_W - FORCE_W;

   logic [SUM_W-1:0]  sum;
   logic [PHYS_W-1:0] phys;
   logic              over;
   win_mode_e         mode;

   logic [PHYS_W-1:0] addr_q;
   logic              valid_q;
   logic              fault_q;

   initial begin
      assert (SEG_W == 16 && OFF_W == 16 && SHIFT == 4 && LOW_W == 20)
         else $fatal(1, "seg_addr_gen: boot entry constants need a 20-bit window");
      assert (((32'(BOOT_SEG) << 4) + 32'(BOOT_OFF)) == BOOT_LINEAR)
         else $fatal(1, "seg_addr_gen: boot entry inconsistent");
   end

   sag_sum #(
      .SEG_W   (SEG_W),
      .OFF_W   (OFF_W),
      .SHIFT   (SHIFT),
      .SUM_W   (SUM_W),
      .GATE_BIT(GATE_BIT),
      .GATE_EN (GATE_EN)
   ) u_sum (
      .seg_i      (seg_i),
      .off_i      (off_i),
      .gate_open_i(a20_en_i),
      .sum_o      (sum)
   );

   sag_window #(
      .PHYS_W (PHYS_W),
      .FORCE_W(FORCE_W),
      .SUM_W  (SUM_W)
   ) u_win (
      .clk   (clk),
      .rst_n (rst_n),
      .jump_i(far_jump_i),
      .sum_i (sum),
      .mode_o(mode),
      .phys_o(phys),
      .over_o(over)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         valid_q <= 1'b0;
         fault_q <= 1'b0;
      end else begin
         valid_q <= req_i & ~over;
         fault_q <= req_i & over;
         if (req_i && !over) addr_q <= phys;
      end
   end

   assign addr_o  = addr_q;
   assign valid_o = valid_q;
   assign fault_o = fault_q;

   p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid_o && fault_o));

   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> (!valid_o && !fault_o && $stable(addr_o)));

   p_top_lines_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && mode == WIN_BOOT) |=> (fault_o || addr_o[PHYS_W-1 -: FORCE_W] == {FORCE_W{1'b1}}));

   p_fault_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> $stable(addr_o));

   p_flat_no_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == WIN_FLAT) |=> !fault_o);

endmodule

// File: tb/tb_seg_addr_gen.sv
module tb_seg_addr_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] seg = '0;
   logic [15:0] off = '0;
   logic        req = 1'b0;
   logic        jmp = 1'b0;
   logic        a20 = 1'b0;
   logic [31:0] addr;
   logic        valid;
   logic        fault;

   int          n_checks = 0;
   int          n_fail = 0;
   bit          done = 1'b0;
   bit          force_m = 1'b1;
   logic [31:0] last_addr = '0;

   always #4 clk = ~clk;

   seg_addr_gen dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .seg_i     (seg),
      .off_i     (off),
      .req_i     (req),
      .far_jump_i(jmp),
      .a20_en_i  (a20),
      .addr_o    (addr),
      .valid_o   (valid),
      .fault_o   (fault)
   );

   task automatic check(input bit ok, input string tag, input logic [33:0] act, input logic [33:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; req = 1'b0; jmp = 1'b0;
      repeat (2) @(negedge clk);
      check(addr == 32'h0 && !valid && !fault, "R9", {valid, fault, addr}, 34'h0);
      rst_n = 1'b1;
      force_m = 1'b1;
      last_addr = '0;
      @(posedge clk); #1;
      check(addr == 32'h0 && !valid && !fault, "R9", {valid, fault, addr}, 34'h0);
   endtask

   task automatic step(input bit r, input logic [15:0] s, input logic [15:0] o,
                       input bit a, input bit j, input string tag);
      logic [20:0] sm;
      logic [31:0] ea;
      bit          ef;
      @(negedge clk);
      req = r; seg = s; off = o; a20 = a; jmp = j;
      sm = {1'b0, s, 4'h0} + {5'h0, o};
      if (!a) sm[20] = 1'b0;
      if (force_m) begin
         ef = sm[20];
         ea = {12'hFFF, sm[19:0]};
      end else begin
         ef = 1'b0;
         ea = {11'h0, sm};
      end
      if (!r) begin
         ef = 1'b0;
         ea = last_addr;
      end else if (ef) begin
         ea = last_addr;
      end
      @(posedge clk); #1;
      check(valid == (r && !ef) && fault == (r && ef) && addr == ea, tag,
            {valid, fault, addr}, {r && !ef, r && ef, ea});
      check(!(valid && fault), "R10", {valid, fault, 32'h0}, 34'h0);
      last_addr = ea;
      if (j) force_m = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R4: boot entry point lands at the top of the space
      step(1, 16'hF000, 16'hFFF0, 1'b0, 1'b0, "R4");
      // R5: carry past bit 19 with line 20 enabled is refused while forced
      step(1, 16'hFFFF, 16'hFFF0, 1'b1, 1'b0, "R5");
      // R2: same pair with line 20 masked stays inside the window
      step(1, 16'hFFFF, 16'hFFF0, 1'b0, 1'b0, "R2");
      // R8: idle cycles
      step(0, 16'h1234, 16'h5678, 1'b1, 1'b0, "R8");
      step(0, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, "R8");
      // R3: forced sweep
      for (int i = 0; i < 256; i++) begin
         for (int a = 0; a < 2; a++) begin
            step(1, 16'(i * 257), 16'(i * 97) ^ 16'hA5F0, a[0], 1'b0, "R3");
         end
      end
      // R6: request in the jump cycle still forced, next one flat
      step(1, 16'hF000, 16'h0010, 1'b0, 1'b1, "R6");
      step(1, 16'h1234, 16'h0005, 1'b0, 1'b0, "R6");
      // R2: wrap behaviour in flat mode
      step(1, 16'hFFFF, 16'hFFF0, 1'b0, 1'b0, "R2");
      step(1, 16'hFFFF, 16'hFFF0, 1'b1, 1'b0, "R2");
      // R7: further jumps change nothing
      step(1, 16'hF000, 16'hFFF0, 1'b1, 1'b1, "R7");
      step(1, 16'hF000, 16'hFFF0, 1'b1, 1'b0, "R7");
      step(0, 16'h0000, 16'h0000, 1'b0, 1'b0, "R8");
      // R1: flat sweep
      for (int i = 0; i < 256; i++) begin
         for (int a = 0; a < 2; a++) begin
            step(1, 16'(i * 257) ^ 16'h0F0F, 16'(i * 193) + 16'h7F00, a[0], 1'b0, "R1");
         end
      end
      // R7: reset reopens the window
      do_reset();
      step(1, 16'hF000, 16'hFFF0, 1'b1, 1'b0, "R7");
      step(1, 16'hFFFF, 16'hFFF0, 1'b1, 1'b0, "R5");
      @(negedge clk);
      req = 1'b0;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule